// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block supplies the integer division value that a PLL feedback divider uses for its next cycle. Its clock ticks once per divider output. Each tick, a cascade of three modulo-M accumulators driven by the fractional word advances by one step. The carries of the three stages are combined with differencing weights (1; 1,−1; 1,−2,1) and added to the integer word. The divider therefore toggles among nearby integer ratios, and the long-run mean is INT + FRAC/MOD. The quantisation error is pushed toward high offset frequencies with a third-order slope.

The modulus is any value from 2 to 4095, so an accumulator wraps by subtracting MOD rather than by dropping a top bit. The integer word is 9 bits wide. A configuration is taken only on a load strobe. The load also clears the accumulators and the carry history, so every load restarts the same sequence. The emitted value is held inside the legal counter window of 31 to 511. A sticky error flag records any clamp and any load of an illegal configuration.

Top module: `frac_ratio_modulator`

## Requirements
- R1: While reset is high and in the first cycle after it, div_valid is 0, range_err is 0 and div_out is 0.
- R2: int_in, frac_in and mod_in are sampled only on a clock edge with load high. After that edge div_valid is 0. On the next edge the first divide value appears with div_valid 1, and one new value follows per edge. Input changes made without load have no effect on the output.
- R3: For a legal configuration with loaded integer I, fraction F and modulus M, let S(n) be the sum of (div_out − I) over the first n valid outputs after a load. Then |S(M·k) − F·k| ≤ 1 for every k ≥ 1.
- R4: For a legal configuration, every valid output lies in the window I−3 to I+4.
- R5: When F = 0, every valid output equals I exactly.
- R6: div_out never goes below 31 or above 511. Any value outside that window is replaced by the nearer limit.
- R7: range_err becomes 1 on the edge that produces a clamped output. It stays 1 until the next load or reset, and a legal load clears it.
- R8: A load with int_in < 31, mod_in < 2 or frac_in ≥ mod_in sets range_err on that edge and runs with a fractional part of zero. The output is then max(int_in, 31) on every cycle.
- R9: Reloading the same configuration reproduces the same output sequence from its first value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One tick per feedback-divider output |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Takes a new configuration and restarts the accumulators |
| int_in | input | 9 | Integer part of the ratio, legal 31..511 |
| frac_in | input | 12 | Fractional numerator, legal 0..mod_in−1 |
| mod_in | input | 12 | Fractional modulus, legal 2..4095 |
| div_out | output | 9 | Divide value for the next divider cycle |
| div_valid | output | 1 | div_out holds a value from the current configuration |
| range_err | output | 1 | Sticky flag for a clamp or an illegal load |

## Verification
The bench sweeps every fraction for every modulus from 2 to 9, plus a few large moduli up to 4095. It checks the running sum at each multiple of the modulus. A wrap that drops a top bit, or a carry taken at the wrong threshold, makes these sums drift by whole units. The window check and the zero-fraction check catch a wrong weight in the differencing chain, which would push values outside I−3..I+4 or add noise where none should be. Runs at the edge integers 31 and 511 check that the clamp holds the output at the limit and raises the sticky flag. Loads of illegal configurations must give a flat output. Reloading a configuration must reproduce the earlier sequence, so any state left uncleared by the load shows up as a difference.

// File: rtl/frac_ratio_modulator.sv
module frac_ratio_modulator #(
  parameter int INT_W  = 9,
  parameter int MOD_W  = 12,
  parameter int INT_LO = 31,
  parameter int INT_HI = 511
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [INT_W-1:0] int_in,
  input  logic [MOD_W-1:0] frac_in,
  input  logic [MOD_W-1:0] mod_in,
  output logic [INT_W-1:0] div_out,
  output logic             div_valid,
  output logic             range_err
);
  localparam int SW = INT_W + 3;
  localparam int AW = MOD_W + 1;
  localparam logic [SW-1:0] LO = SW'(INT_LO);
  localparam logic [SW-1:0] HI = SW'(INT_HI);

  logic [INT_W-1:0] int_q;
  logic [MOD_W-1:0] frac_q, mod_q, acc1, acc2, acc3;
  logic             run, c2d, c3d1, c3d2;

  logic [AW-1:0] s1, s2, s3, m_ext;
  logic          c1, c2, c3;
  logic [MOD_W-1:0] r1, r2, r3;

  assign m_ext = {1'b0, mod_q};
  assign s1 = {1'b0, acc1} + {1'b0, frac_q};
  assign c1 = s1 >= m_ext;
  assign r1 = c1 ? MOD_W'(s1 - m_ext) : s1[MOD_W-1:0];
  assign s2 = {1'b0, acc2} + {1'b0, r1};
  assign c2 = s2 >= m_ext;
  assign r2 = c2 ? MOD_W'(s2 - m_ext) : s2[MOD_W-1:0];
  assign s3 = {1'b0, acc3} + {1'b0, r2};
  assign c3 = s3 >= m_ext;
  assign r3 = c3 ? MOD_W'(s3 - m_ext) : s3[MOD_W-1:0];

  logic [SW-1:0] raw;
  logic          below, above;
  logic [INT_W-1:0] clamped;

  assign raw = SW'(int_q) + SW'(c1) + SW'(c2) + SW'(c3) + SW'(c3d2)
             - SW'(c2d) - (SW'(c3d1) << 1);
  assign below = $signed(raw) < $signed(LO);
  assign above = $signed(raw) > $signed(HI);
  assign clamped = below ? INT_W'(INT_LO) : above ? INT_W'(INT_HI) : raw[INT_W-1:0];

  logic cfg_bad;
  assign cfg_bad = (int_in < INT_W'(INT_LO)) || (mod_in < MOD_W'(2)) || (frac_in >= mod_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= '0; frac_q <= '0; mod_q <= '0;
      acc1 <= '0; acc2 <= '0; acc3 <= '0;
      c2d <= 1'b0; c3d1 <= 1'b0; c3d2 <= 1'b0;
      run <= 1'b0; div_valid <= 1'b0; range_err <= 1'b0; div_out <= '0;
    end else if (load) begin
      int_q  <= int_in;
      frac_q <= cfg_bad ? '0 : frac_in;
      mod_q  <= (mod_in < MOD_W'(2)) ? MOD_W'(2) : mod_in;
      acc1 <= '0; acc2 <= '0; acc3 <= '0;
      c2d <= 1'b0; c3d1 <= 1'b0; c3d2 <= 1'b0;
      run <= 1'b1; div_valid <= 1'b0; range_err <= cfg_bad;
    end else if (run) begin
      acc1 <= r1; acc2 <= r2; acc3 <= r3;
      c2d <= c2; c3d1 <= c3; c3d2 <= c3d1;
      div_out <= clamped;
      div_valid <= 1'b1;
      if (below || above) range_err <= 1'b1;
    end
  end

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    load |=> !div_valid); // R2
  AST_RESIDUE: assert property (@(posedge clk) disable iff (rst)
    run |-> (acc1 < mod_q) && (acc2 < mod_q) && (acc3 < mod_q)); // R3
  AST_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (div_valid && !range_err) |->
      (({1'b0, div_out} + (INT_W+1)'(3)) >= {1'b0, int_q}) &&
      ({1'b0, div_out} <= ({1'b0, int_q} + (INT_W+1)'(4)))); // R4
  AST_FLAT_WHEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (div_valid && frac_q == '0 && !range_err) |-> div_out == int_q); // R5
  AST_LIMITS: assert property (@(posedge clk) disable iff (rst)
    div_valid |-> (div_out >= INT_W'(INT_LO)) && (div_out <= INT_W'(INT_HI))); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (range_err && !load) |=> range_err); // R7
endmodule

// File: tb/frac_ratio_modulator_test.sv
module frac_ratio_modulator_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [8:0]  int_in = '0;
  logic [11:0] frac_in = '0;
  logic [11:0] mod_in = '0;
  logic [8:0]  div_out;
  logic        div_valid, range_err;

  int checks = 0;
  int fails = 0;
  int smp [0:63];
  int ref_seq [0:63];

  always #10 clk = ~clk;

  frac_ratio_modulator uut (
    .clk(clk), .rst(rst), .load(load), .int_in(int_in), .frac_in(frac_in),
    .mod_in(mod_in), .div_out(div_out), .div_valid(div_valid), .range_err(range_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int i, input int f, input int m);
    @(negedge clk);
    load = 1'b1; int_in = 9'(i); frac_in = 12'(f); mod_in = 12'(m);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic collect(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      smp[j] = div_out;
    end
  endtask

  task automatic run_cfg(input int i, input int f, input int m, input int k);
    int sum = 0;
    int lo_bad = 0;
    int flat_bad = 0;
    do_load(i, f, m);
    for (int n = 1; n <= m * k; n++) begin
      @(negedge clk);
      sum += int'(div_out) - i;
      if (int'(div_out) < i - 3 || int'(div_out) > i + 4 || !div_valid) lo_bad++;
      if (f == 0 && int'(div_out) != i) flat_bad++;
      if (n % m == 0) begin
        int want = f * (n / m);
        chk(sum >= want - 1 && sum <= want + 1, "R3 mean over MOD*k", sum, want);
      end
    end
    chk(lo_bad == 0, "R4 window", lo_bad, 0);
    if (f == 0) chk(flat_bad == 0, "R5 zero fraction", flat_bad, 0);
    chk(range_err == 1'b0, "R7 no error when legal", range_err, 0);
  endtask

  initial begin
    bit done = 1'b0;
    fork
      begin
        repeat (3) @(negedge clk);
        chk(div_valid == 1'b0 && range_err == 1'b0 && div_out == '0, "R1 reset state",
            {div_valid, range_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(div_valid == 1'b0 && div_out == '0, "R1 after reset", div_out, 0);

        do_load(200, 1, 3);
        chk(div_valid == 1'b0, "R2 valid low after load edge", div_valid, 0);
        @(negedge clk);
        chk(div_valid == 1'b1, "R2 first value next edge", div_valid, 1);
        int_in = 9'd400; frac_in = 12'd0; mod_in = 12'd5;
        collect(12);
        begin
          int bad = 0;
          for (int j = 0; j < 12; j++) if (smp[j] < 197 || smp[j] > 204) bad++;
          chk(bad == 0, "R2 inputs ignored without load", bad, 0);
        end

        for (int m = 2; m <= 9; m++)
          for (int f = 0; f < m; f++)
            run_cfg(200, f, m, 3);
        run_cfg(300, 1, 4095, 2);
        run_cfg(300, 4094, 4095, 2);
        run_cfg(100, 333, 1000, 4);
        run_cfg(450, 1234, 2500, 2);
        run_cfg(35, 0, 4095, 1);

        do_load(150, 5, 11);
        collect(33);
        for (int j = 0; j < 33; j++) ref_seq[j] = smp[j];
        do_load(150, 5, 11);
        collect(33);
        begin
          int diff = 0;
          for (int j = 0; j < 33; j++) if (smp[j] != ref_seq[j]) diff++;
          chk(diff == 0, "R9 reload repeats sequence", diff, 0);
        end

        do_load(511, 3, 7);
        collect(50);
        begin
          int bad = 0;
          for (int j = 0; j < 50; j++) if (smp[j] > 511 || smp[j] < 508) bad++;
          chk(bad == 0, "R6 clamp at top", bad, 0);
        end
        chk(range_err == 1'b1, "R7 clamp sets flag", range_err, 1);
        do_load(200, 3, 7);
        chk(range_err == 1'b0, "R7 legal load clears flag", range_err, 0);

        do_load(31, 3, 7);
        collect(50);
        begin
          int bad = 0;
          for (int j = 0; j < 50; j++) if (smp[j] < 31 || smp[j] > 35) bad++;
          chk(bad == 0, "R6 clamp at bottom", bad, 0);
        end

        do_load(20, 5, 7);
        chk(range_err == 1'b1, "R8 low integer flagged", range_err, 1);
        collect(20);
        begin
          int bad = 0;
          for (int j = 0; j < 20; j++) if (smp[j] != 31) bad++;
          chk(bad == 0, "R8 low integer output 31", bad, 0);
        end
        do_load(200, 9, 7);
        chk(range_err == 1'b1, "R8 fraction >= modulus flagged", range_err, 1);
        collect(20);
        begin
          int bad = 0;
          for (int j = 0; j < 20; j++) if (smp[j] != 200) bad++;
          chk(bad == 0, "R8 fraction dropped", bad, 0);
        end
        do_load(200, 0, 1);
        chk(range_err == 1'b1, "R8 modulus below 2 flagged", range_err, 1);
        collect(10);
        chk(smp[9] == 200, "R8 flat output", smp[9], 200);
        done = 1'b1;
      end
      begin
        repeat (190000) @(posedge clk);
        if (!done) begin
          fails++;
          checks++;
          $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule